// File: doc/BRIEF.md
# Two-Port Transceiver-Interface Collision Multiplexer

This block is the digital control core that lets two data terminals share one medium attachment port. Each terminal port brings a transmit activity flag and a data bit. The medium side brings receive activity, receive data and a collision-present flag. The block picks the terminal whose stream drives the medium transmit output. It sends one collision waveform to both terminals when they transmit together or when the medium reports a collision.

A two-bit mode input turns on local loopback, with or without a post-transmit signal-quality test pulse. In loopback the active terminal stream is returned to both terminal receive outputs, so two terminals can talk with no medium attachment present. The collision indication is a square wave built from a divider on the sample clock. Four active-low LED outputs are stretched by counters so that short bursts stay visible. All timing is counted in sample-clock cycles.

Top module: `aui_collision_mux`

## Requirements
- R1: When tx1_act and tx2_act are both high in a sampled cycle, both bits of dte_col are high in the next cycle.
- R2: When mau_col is high in a sampled cycle, both bits of dte_col are high in the next cycle.
- R3: While a collision is being signalled, dte_col[0] and dte_col[1] are equal. They are high for COL_HALF cycles and then low for COL_HALF cycles, repeating, and the first cycle is high. When no collision is being signalled, dte_col is 2'b00.
- R4: After the last cycle with a collision cause, the waveform keeps running for COL_TAIL more clock edges. From the next edge on, dte_col is 2'b00.
- R5: Mode encoding: mode 2'b00 enables loopback and the quality test, mode 2'b01 enables loopback only, and mode 2'b10 or 2'b11 disables both.
- R6: When only one port is active, mau_tx_act and mau_tx_dat carry that port's flag and data one cycle later. When both ports are active, port 1's data is forwarded.
- R7: When neither port is active, mau_tx_act and mau_tx_dat are 0 in the next cycle.
- R8: In loopback modes, both bits of dte_rx_act and dte_rx_dat carry the stream that is forwarded to mau_tx one cycle later. Medium receive inputs have no effect.
- R9: With loopback disabled, both bits of dte_rx_act and dte_rx_dat copy mau_rx_act and mau_rx_dat one cycle later.
- R10: In mode 2'b00, when transmit activity (either port) is sampled low at edge k after being high at edge k-1, a collision cause is raised for SQE_LEN cycles starting at edge k+SQE_DLY. dte_col is low after edge k+SQE_DLY and high after edge k+SQE_DLY+1. In other modes no test pulse occurs. New activity cancels a pending pulse.
- R11: led_tx_n[0], led_tx_n[1], led_rx_n and led_col_n are active low. Each one is low after every edge at which its activity is sampled and for LED_HOLD-1 edges more, then high. The activities are port 1 transmit, port 2 transmit, receive-output activity, and any collision cause.
- R12: While rst is high, all data and collision outputs are 0 and all LED outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Loopback / quality-test select |
| tx1_act | input | 1 | Port 1 transmit activity |
| tx1_dat | input | 1 | Port 1 transmit data |
| tx2_act | input | 1 | Port 2 transmit activity |
| tx2_dat | input | 1 | Port 2 transmit data |
| mau_rx_act | input | 1 | Medium receive activity |
| mau_rx_dat | input | 1 | Medium receive data |
| mau_col | input | 1 | Medium collision present |
| mau_tx_act | output | 1 | Medium transmit activity |
| mau_tx_dat | output | 1 | Medium transmit data |
| dte_rx_act | output | 2 | Receive activity to ports 2..1 |
| dte_rx_dat | output | 2 | Receive data to ports 2..1 |
| dte_col | output | 2 | Collision waveform to ports 2..1 |
| led_tx_n | output | 2 | Stretched transmit LEDs, active low |
| led_rx_n | output | 1 | Stretched receive LED, active low |
| led_col_n | output | 1 | Stretched collision LED, active low |

## Verification
The bench keeps COL_HALF at 2, so the four-cycle collision period matches a 40 MHz sample clock. It shrinks the other timers to COL_TAIL=4, SQE_DLY=6, SQE_LEN=5 and LED_HOLD=10. With these values, the end of each timing window can be checked at its exact edge within a few dozen cycles: the collision tail, the delayed test pulse, its suppression in the other modes, and the LED off point. The default millisecond-scale values would put these edges out of reach.

// File: rtl/aui_mux_pkg.sv
package aui_mux_pkg;

    typedef enum logic [1:0] {
        MODE_LOOP_SQE = 2'b00,
        MODE_LOOP     = 2'b01,
        MODE_OFF_A    = 2'b10,
        MODE_OFF_B    = 2'b11
    } mux_mode_e;

    typedef struct packed {
        logic act;
        logic dat;
    } lane_t;

    localparam lane_t LANE_IDLE = '{act: 1'b0, dat: 1'b0};

    function automatic logic loop_on(input mux_mode_e m);
        return (m == MODE_LOOP_SQE) || (m == MODE_LOOP);
    endfunction

    function automatic logic sqe_on(input mux_mode_e m);
        return m == MODE_LOOP_SQE;
    endfunction

endpackage

// File: rtl/aui_tx_select.sv
module aui_tx_select
    import aui_mux_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  mux_mode_e mode,
    input  lane_t     tx1,
    input  lane_t     tx2,
    input  lane_t     mau_rx,
    output lane_t     mau_tx,
    output lane_t     dte_rx,
    output logic      contend
);

    lane_t sel;
    lane_t rx_nxt;

    always_comb begin
        if (tx1.act)      sel = tx1;
        else if (tx2.act) sel = tx2;
        else              sel = LANE_IDLE;
        rx_nxt = loop_on(mode) ? sel : mau_rx;
    end

    assign contend = tx1.act & tx2.act;

    always_ff @(posedge clk) begin
        if (rst) begin
            mau_tx <= LANE_IDLE;
            dte_rx <= LANE_IDLE;
        end else begin
            mau_tx <= sel;
            dte_rx <= rx_nxt;
        end
    end

endmodule

// File: rtl/aui_sqe_timer.sv
module aui_sqe_timer #(
    parameter int SQE_DLY = 44,
    parameter int SQE_LEN = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic tx_busy,
    output logic pulse
);

    localparam int MAXC = (SQE_DLY > SQE_LEN) ? SQE_DLY : SQE_LEN;
    localparam int CW   = $clog2(MAXC + 1);

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_FIRE} sqe_st_e;

    sqe_st_e       st;
    logic [CW-1:0] cnt;
    logic          busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            busy_q <= 1'b0;
        end else begin
            busy_q <= tx_busy;
            if (tx_busy || !enable) begin
                st  <= ST_IDLE;
                cnt <= '0;
            end else begin
                unique case (st)
                    ST_IDLE: if (busy_q) begin
                        st  <= ST_WAIT;
                        cnt <= CW'(SQE_DLY - 1);
                    end
                    ST_WAIT: if (cnt == '0) begin
                        st  <= ST_FIRE;
                        cnt <= CW'(SQE_LEN - 1);
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                    ST_FIRE: if (cnt == '0) begin
                        st <= ST_IDLE;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    assign pulse = (st == ST_FIRE);

endmodule

// File: rtl/aui_col_wave.sv
module aui_col_wave #(
    parameter int COL_HALF = 2,
    parameter int COL_TAIL = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic wave,
    output logic busy
);

    localparam int PW = $clog2(COL_HALF + 1);
    localparam int TW = $clog2(COL_TAIL + 1);

    logic [PW-1:0] ph;
    logic [TW-1:0] tail;
    logic          ph_end;

    assign ph_end = (ph == PW'(COL_HALF - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= '0;
            tail <= '0;
            wave <= 1'b0;
            busy <= 1'b0;
        end else if (req && !busy) begin
            busy <= 1'b1;
            wave <= 1'b1;
            ph   <= '0;
            tail <= TW'(COL_TAIL);
        end else if (busy && !req && tail == '0) begin
            busy <= 1'b0;
            wave <= 1'b0;
            ph   <= '0;
        end else if (busy) begin
            if (req) tail <= TW'(COL_TAIL);
            else     tail <= tail - TW'(1);
            if (ph_end) begin
                ph   <= '0;
                wave <= ~wave;
            end else begin
                ph <= ph + PW'(1);
            end
        end
    end

endmodule

// File: rtl/aui_led_stretch.sv
module aui_led_stretch #(
    parameter int LED_HOLD = 2_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic act,
    output logic lit_n
);

    localparam int CW = $clog2(LED_HOLD + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (act)         cnt <= CW'(LED_HOLD);
        else if (cnt != '0)   cnt <= cnt - CW'(1);
    end

    assign lit_n = (cnt == '0);

endmodule

// File: rtl/aui_collision_mux.sv
module aui_collision_mux
    import aui_mux_pkg::*;
#(
    parameter int COL_HALF = 2,
    parameter int COL_TAIL = 16,
    parameter int SQE_DLY  = 44,
    parameter int SQE_LEN  = 40,
    parameter int LED_HOLD = 2_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       tx1_act,
    input  logic       tx1_dat,
    input  logic       tx2_act,
    input  logic       tx2_dat,
    input  logic       mau_rx_act,
    input  logic       mau_rx_dat,
    input  logic       mau_col,
    output logic       mau_tx_act,
    output logic       mau_tx_dat,
    output logic [1:0] dte_rx_act,
    output logic [1:0] dte_rx_dat,
    output logic [1:0] dte_col,
    output logic [1:0] led_tx_n,
    output logic       led_rx_n,
    output logic       led_col_n
);

    localparam int NLED = 4;

    mux_mode_e  mode_e;
    lane_t      tx1_s, tx2_s, mrx_s, mtx_s, drx_s;
    logic       contend, sqe_pulse, col_req, col_wave, col_busy;
    logic       rx_led_act;
    logic [NLED-1:0] led_act, led_q_n;

    assign mode_e = mux_mode_e'(mode);
    assign tx1_s  = '{act: tx1_act, dat: tx1_dat};
    assign tx2_s  = '{act: tx2_act, dat: tx2_dat};
    assign mrx_s  = '{act: mau_rx_act, dat: mau_rx_dat};

    aui_tx_select u_sel (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode_e),
        .tx1     (tx1_s),
        .tx2     (tx2_s),
        .mau_rx  (mrx_s),
        .mau_tx  (mtx_s),
        .dte_rx  (drx_s),
        .contend (contend)
    );

    aui_sqe_timer #(.SQE_DLY(SQE_DLY), .SQE_LEN(SQE_LEN)) u_sqe (
        .clk     (clk),
        .rst     (rst),
        .enable  (sqe_on(mode_e)),
        .tx_busy (tx1_act | tx2_act),
        .pulse   (sqe_pulse)
    );

    assign col_req = contend | mau_col | sqe_pulse;

    aui_col_wave #(.COL_HALF(COL_HALF), .COL_TAIL(COL_TAIL)) u_col (
        .clk  (clk),
        .rst  (rst),
        .req  (col_req),
        .wave (col_wave),
        .busy (col_busy)
    );

    assign rx_led_act = loop_on(mode_e) ? (tx1_act | tx2_act) : mau_rx_act;
    assign led_act    = {col_req, rx_led_act, tx2_act, tx1_act};

    for (genvar g = 0; g < NLED; g++) begin : g_led
        aui_led_stretch #(.LED_HOLD(LED_HOLD)) u_led (
            .clk   (clk),
            .rst   (rst),
            .act   (led_act[g]),
            .lit_n (led_q_n[g])
        );
    end

    assign mau_tx_act = mtx_s.act;
    assign mau_tx_dat = mtx_s.dat;
    assign dte_rx_act = {2{drx_s.act}};
    assign dte_rx_dat = {2{drx_s.dat}};
    assign dte_col    = {2{col_wave}};
    assign led_tx_n   = led_q_n[1:0];
    assign led_rx_n   = led_q_n[2];
    assign led_col_n  = led_q_n[3];

endmodule

// File: rtl/aui_collision_mux_chk.sv
module aui_collision_mux_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       tx1_act,
    input logic       tx1_dat,
    input logic       tx2_act,
    input logic       mau_rx_dat,
    input logic       mau_col,
    input logic       mau_tx_act,
    input logic       mau_tx_dat,
    input logic [1:0] dte_rx_dat,
    input logic [1:0] dte_col,
    input logic [1:0] led_tx_n,
    input logic       col_busy
);

    a_r1_contention: assert property (@(posedge clk) disable iff (rst)
        (tx1_act && tx2_act) |=> col_busy);

    a_r2_mau_col: assert property (@(posedge clk) disable iff (rst)
        mau_col |=> col_busy);

    a_r3_quiet: assert property (@(posedge clk) disable iff (rst)
        !col_busy |-> (dte_col == 2'b00));

    a_r6_single: assert property (@(posedge clk) disable iff (rst)
        (tx1_act && !tx2_act) |=> (mau_tx_act && mau_tx_dat == $past(tx1_dat)));

    a_r7_idle: assert property (@(posedge clk) disable iff (rst)
        (!tx1_act && !tx2_act) |=> (!mau_tx_act && !mau_tx_dat));

    a_r9_direct: assert property (@(posedge clk) disable iff (rst)
        mode[1] |=> (dte_rx_dat == {2{$past(mau_rx_dat)}}));

    a_r11_led: assert property (@(posedge clk) disable iff (rst)
        tx1_act |=> !led_tx_n[0]);

endmodule

bind aui_collision_mux aui_collision_mux_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .tx1_act    (tx1_act),
    .tx1_dat    (tx1_dat),
    .tx2_act    (tx2_act),
    .mau_rx_dat (mau_rx_dat),
    .mau_col    (mau_col),
    .mau_tx_act (mau_tx_act),
    .mau_tx_dat (mau_tx_dat),
    .dte_rx_dat (dte_rx_dat),
    .dte_col    (dte_col),
    .led_tx_n   (led_tx_n),
    .col_busy   (col_busy)
);

// File: tb/aui_collision_mux_test.sv
module aui_collision_mux_test;

    localparam int HALF = 2;
    localparam int TAIL = 4;
    localparam int DLY  = 6;
    localparam int LEN  = 5;
    localparam int HOLD = 10;
    localparam int NVEC = 10;

    // {mode[1:0], t1a, t1d, t2a, t2d, ra, rd, exp_ta, exp_td, exp_ra, exp_rd}
    localparam logic [11:0] VEC [NVEC] = '{
        12'b10_1100_00_11_00,
        12'b10_1000_11_10_11,
        12'b10_0011_10_11_10,
        12'b10_0000_00_00_00,
        12'b10_1011_00_10_00,
        12'b00_0011_10_11_11,
        12'b01_1000_11_10_10,
        12'b01_0000_11_00_00,
        12'b11_0010_11_10_11,
        12'b00_1110_00_11_11
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b10;
    logic       tx1_act = 0, tx1_dat = 0, tx2_act = 0, tx2_dat = 0;
    logic       mau_rx_act = 0, mau_rx_dat = 0, mau_col = 0;
    logic       mau_tx_act, mau_tx_dat, led_rx_n, led_col_n;
    logic [1:0] dte_rx_act, dte_rx_dat, dte_col, led_tx_n;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    aui_collision_mux #(
        .COL_HALF(HALF), .COL_TAIL(TAIL), .SQE_DLY(DLY),
        .SQE_LEN(LEN), .LED_HOLD(HOLD)
    ) uut (
        .clk(clk), .rst(rst), .mode(mode),
        .tx1_act(tx1_act), .tx1_dat(tx1_dat),
        .tx2_act(tx2_act), .tx2_dat(tx2_dat),
        .mau_rx_act(mau_rx_act), .mau_rx_dat(mau_rx_dat), .mau_col(mau_col),
        .mau_tx_act(mau_tx_act), .mau_tx_dat(mau_tx_dat),
        .dte_rx_act(dte_rx_act), .dte_rx_dat(dte_rx_dat), .dte_col(dte_col),
        .led_tx_n(led_tx_n), .led_rx_n(led_rx_n), .led_col_n(led_col_n)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic quiet(input int n);
        tx1_act = 0; tx2_act = 0; tx1_dat = 0; tx2_dat = 0;
        mau_col = 0; mau_rx_act = 0; mau_rx_dat = 0;
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        // R12 reset state
        chk("R12 data", {mau_tx_act, mau_tx_dat, dte_rx_act, dte_rx_dat}, 8'h00);
        chk("R12 col", {6'b0, dte_col}, 8'h00);
        chk("R12 leds", {4'b0, led_tx_n, led_rx_n, led_col_n}, 8'h0f);
        rst = 1'b0;
        step();

        // R5 R6 R7 R8 R9 vector table
        for (int v = 0; v < NVEC; v++) begin
            {mode, tx1_act, tx1_dat, tx2_act, tx2_dat, mau_rx_act, mau_rx_dat} = VEC[v][11:2+4-2];
            step();
            chk($sformatf("R6 R7 mau_tx vec%0d", v), {6'b0, mau_tx_act, mau_tx_dat}, {6'b0, VEC[v][3:2]});
            chk($sformatf("R8 R9 R5 dte_rx vec%0d", v), {4'b0, dte_rx_act, dte_rx_dat},
                {4'b0, {2{VEC[v][1]}}, {2{VEC[v][0]}}});
        end

        // R1 R3 R4 contention waveform and tail
        mode = 2'b10;
        quiet(30);
        tx1_act = 1; tx2_act = 1; tx2_dat = 1;
        for (int j = 0; j < 8; j++) begin
            step();
            chk($sformatf("R1 R3 wave cyc%0d", j), {6'b0, dte_col}, ((j / HALF) % 2 == 0) ? 8'h03 : 8'h00);
        end
        chk("R11 col led lit", {7'b0, led_col_n}, 8'h00);
        tx1_act = 0; tx2_act = 0; tx2_dat = 0;
        step();
        chk("R4 tail first", {6'b0, dte_col}, 8'h03);
        step();
        chk("R4 tail second", {6'b0, dte_col}, 8'h03);
        step(); step(); step();
        chk("R4 tail over", {6'b0, dte_col}, 8'h00);
        step();
        chk("R4 stays low", {6'b0, dte_col}, 8'h00);

        // R2 medium collision propagation
        quiet(30);
        mau_col = 1;
        step();
        chk("R2 mau col first", {6'b0, dte_col}, 8'h03);
        step(); step();
        chk("R2 R3 mau col low half", {6'b0, dte_col}, 8'h00);
        mau_col = 0;

        // R10 quality-test pulse in mode 00
        quiet(30);
        mode = 2'b00;
        tx1_act = 1; tx1_dat = 1;
        step(); step(); step();
        tx1_act = 0; tx1_dat = 0;
        for (int j = 1; j <= DLY + 1; j++) step();
        chk("R10 no pulse before delay", {6'b0, dte_col}, 8'h00);
        step();
        chk("R10 pulse present", {6'b0, dte_col}, 8'h03);

        // R10 R5 no pulse in loopback-only mode
        quiet(40);
        mode = 2'b01;
        tx2_act = 1; tx2_dat = 1;
        step(); step(); step();
        tx2_act = 0; tx2_dat = 0;
        begin
            logic seen;
            seen = 1'b0;
            for (int j = 0; j < 25; j++) begin
                step();
                if (dte_col != 2'b00) seen = 1'b1;
            end
            chk("R10 R5 no pulse mode 01", {7'b0, seen}, 8'h00);
        end

        // R11 LED stretch
        mode = 2'b10;
        quiet(30);
        tx1_act = 1;
        step();
        tx1_act = 0;
        chk("R11 tx1 led lit", {6'b0, led_tx_n}, 8'h02);
        for (int j = 1; j < HOLD; j++) step();
        chk("R11 tx1 led last lit", {6'b0, led_tx_n}, 8'h02);
        step();
        chk("R11 tx1 led dark", {6'b0, led_tx_n}, 8'h03);
        mau_rx_act = 1;
        step();
        mau_rx_act = 0;
        chk("R11 rx led lit", {7'b0, led_rx_n}, 8'h00);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule